// File: doc/BRIEF.md
# Long-Register Incremental Append Controller

This block sits behind a serial-bus slave's byte engine and builds wide control registers out of write traffic. The byte engine hands it one event per clock: a start (or repeated start), the device-address byte with its direction bit, the subaddress byte, a data byte, or a stop. A long register is 4, 8, 12 or 20 bytes wide. It may arrive in one piece, or it may be spread across several bus transactions so that other traffic can get through in between.

The first transaction names the target subaddress and carries four bytes. Each later transaction writes exactly four bytes to the reserved append subaddress 0xFE. These bytes are placed after the bytes already held. When the held byte count reaches the register's width, the block raises a one-cycle commit with the assembled value and its subaddress. A partial register is discarded, and a one-cycle flush pulse is raised, in these cases:

- a fresh subaddress cuts in;
- a chunk has a byte count other than four;
- a read is addressed to the device while a register is partly filled.

Top module: `lra_append_ctrl`

## Requirements
- R1: Event codes on `ev_kind` are start 0, address 1, subaddress 2, data 3, stop 4. Only address byte 0x6C (7-bit address 0x36, write) or 0x6D (read) selects the device. A transaction to any other address raises neither commit nor flush and leaves a partly filled register able to complete.
- R2: The register width in bytes is looked up from the subaddress. Subaddresses 0x40–0x4F are 8 bytes, 0x50–0x5F are 12 bytes, 0x60–0x6F are 20 bytes, and every other subaddress is 4 bytes. `commit_words` reports the width in four-byte words (2, 3, 5 or 1).
- R3: A write to subaddress 0xFE with exactly four data bytes appends those bytes, in order, after the bytes already held for the open register.
- R4: When the held count reaches the register width, `commit_valid` is high for exactly one cycle. This is the cycle after the stop (or repeated start) that ends the final chunk. In that cycle `commit_sub` holds the subaddress and `commit_data` holds the bytes right-justified, with the first byte received at the most significant position.
- R5: A 4-byte register commits at the end of its first transaction.
- R6: A write of a subaddress other than 0xFE while a register is partly filled raises `flush_pulse` the cycle after the subaddress event and discards the held bytes. The new subaddress then starts a fresh register.
- R7: A chunk with 1–3 or more than four data bytes, or an append to 0xFE with no data bytes, raises `flush_pulse` the cycle after the stop or repeated start that ends it. The partial register is then closed.
- R8: A read address byte (0x6D) while a register is partly filled raises `flush_pulse` the cycle after that event and closes the register.
- R9: A write to 0xFE with no register open raises `flush_pulse` the cycle after the subaddress event, and its data is ignored.
- R10: After reset, and in every cycle that does not follow an accepted event with a result, `commit_valid` and `flush_pulse` are low. The two are never high together.
- R11: A write that sets a non-append subaddress and carries no data bytes raises no flush and opens no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | An event is presented this cycle |
| ev_kind | input | 3 | Event code (start 0, address 1, subaddress 2, data 3, stop 4) |
| ev_byte | input | 8 | Byte carried by address, subaddress and data events |
| commit_valid | output | 1 | One-cycle strobe: an assembled register is complete |
| commit_sub | output | 8 | Subaddress of the committed register |
| commit_words | output | 3 | Width of the committed register in four-byte words |
| commit_data | output | 160 | Assembled value, right-justified, first byte most significant |
| flush_pulse | output | 1 | One-cycle strobe: held bytes were discarded |

## Verification
Every result is registered once. A commit or flush therefore appears exactly one cycle after the event that causes it: the stop or repeated start for chunk-length outcomes, the subaddress event for cut-in and orphan appends, and the address event for reads. The bench presents one event per cycle at the falling edge and advances its queue-based model with that event. At the next falling edge it compares both strobes, and the committed payload when a commit is due, with the model. This holds the design to that one-cycle latency on every clock, including idle ones.

// File: rtl/lra_pkg.sv
`timescale 1ns/1ps
package lra_pkg;

    typedef enum logic [2:0] {
        EV_START = 3'd0,
        EV_ADDR  = 3'd1,
        EV_SUB   = 3'd2,
        EV_DATA  = 3'd3,
        EV_STOP  = 3'd4
    } ev_kind_e;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_ADDR = 3'd1,
        PH_SUB  = 3'd2,
        PH_DATA = 3'd3,
        PH_SKIP = 3'd4
    } phase_e;

    localparam logic [7:0] APPEND_SUB  = 8'hFE;
    localparam int         CHUNK_BYTES = 4;

endpackage

// File: rtl/lra_len_table.sv
`timescale 1ns/1ps
module lra_len_table #(
    parameter int                           NUM_RANGES  = 3,
    parameter int                           WORD_W      = 3,
    parameter logic [7:0]                   RANGE_MASK  = 8'hF0,
    parameter logic [NUM_RANGES*8-1:0]      RANGE_BASE  = 24'h60_50_40,
    parameter logic [NUM_RANGES*WORD_W-1:0] RANGE_WORDS = {3'd5, 3'd3, 3'd2}
) (
    input  logic [7:0]        sub_i,
    output logic [WORD_W-1:0] words_o
);

    logic [NUM_RANGES-1:0] hit;

    for (genvar g = 0; g < NUM_RANGES; g++) begin : g_range
        assign hit[g] = ((sub_i & RANGE_MASK) == RANGE_BASE[g*8 +: 8]);
    end

    // lowest-numbered matching range wins; unmatched subaddresses are one word
    always_comb begin
        words_o = WORD_W'(1);
        for (int i = NUM_RANGES - 1; i >= 0; i--) begin
            if (hit[i]) begin
                words_o = RANGE_WORDS[i*WORD_W +: WORD_W];
            end
        end
    end

endmodule

// File: rtl/lra_addr_match.sv
`timescale 1ns/1ps
module lra_addr_match #(
    parameter logic [6:0] DEV_ADDR = 7'h36
) (
    input  logic [7:0] addr_byte_i,
    output logic       hit_o,
    output logic       read_o
);

    assign hit_o  = (addr_byte_i[7:1] == DEV_ADDR);
    assign read_o = addr_byte_i[0];

endmodule

// File: rtl/lra_shift_buf.sv
`timescale 1ns/1ps
module lra_shift_buf #(
    parameter int BYTES = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             shift_i,
    input  logic [7:0]       byte_i,
    output logic [BYTES*8-1:0] data_o
);

    localparam int W = BYTES * 8;

    logic [W-1:0] data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (clr_i) begin
            data_d = '0;
        end else if (shift_i) begin
            data_d = {data_q[W-9:0], byte_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else begin
            data_q <= data_d;
        end
    end

    assign data_o = data_q;

endmodule

// File: rtl/lra_append_ctrl.sv
`timescale 1ns/1ps
module lra_append_ctrl
    import lra_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR   = 7'h36,
    parameter int         MAX_WORDS  = 5,
    parameter int         NUM_RANGES = 3,
    parameter logic [7:0] RANGE_MASK = 8'hF0,
    parameter logic [NUM_RANGES*8-1:0] RANGE_BASE = 24'h60_50_40,
    parameter logic [NUM_RANGES*$clog2(MAX_WORDS+1)-1:0] RANGE_WORDS = {3'd5, 3'd3, 3'd2}
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  ev_valid,
    input  logic [2:0]                            ev_kind,
    input  logic [7:0]                            ev_byte,
    output logic                                  commit_valid,
    output logic [7:0]                            commit_sub,
    output logic [$clog2(MAX_WORDS+1)-1:0]        commit_words,
    output logic [MAX_WORDS*CHUNK_BYTES*8-1:0]    commit_data,
    output logic                                  flush_pulse
);

    localparam int WORD_W    = $clog2(MAX_WORDS + 1);
    localparam int MAX_BYTES = MAX_WORDS * CHUNK_BYTES;
    localparam int CNT_W     = 3;

    typedef struct packed {
        phase_e              phase;
        logic                open;    // at least one good chunk held, not complete
        logic                append;  // current chunk targets the append subaddress
        logic [7:0]          sub;
        logic [WORD_W-1:0]   words;   // register width in words
        logic [WORD_W-1:0]   fill;    // words already accepted
        logic [CNT_W-1:0]    cnt;     // bytes in current chunk, saturates at 5
        logic                commit;
        logic                flush;
    } ctl_t;

    ctl_t s_d, s_q;

    logic              addr_hit, addr_read;
    logic [WORD_W-1:0] lut_words;
    logic              buf_clr, buf_shift;
    logic [WORD_W-1:0] fill_inc;
    ev_kind_e          kind;

    assign kind     = ev_kind_e'(ev_kind);
    assign fill_inc = s_q.fill + WORD_W'(1);

    lra_addr_match #(
        .DEV_ADDR (DEV_ADDR)
    ) u_addr (
        .addr_byte_i (ev_byte),
        .hit_o       (addr_hit),
        .read_o      (addr_read)
    );

    lra_len_table #(
        .NUM_RANGES  (NUM_RANGES),
        .WORD_W      (WORD_W),
        .RANGE_MASK  (RANGE_MASK),
        .RANGE_BASE  (RANGE_BASE),
        .RANGE_WORDS (RANGE_WORDS)
    ) u_len (
        .sub_i   (ev_byte),
        .words_o (lut_words)
    );

    lra_shift_buf #(
        .BYTES (MAX_BYTES)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (buf_clr),
        .shift_i (buf_shift),
        .byte_i  (ev_byte),
        .data_o  (commit_data)
    );

    always_comb begin
        s_d        = s_q;
        s_d.commit = 1'b0;
        s_d.flush  = 1'b0;
        buf_clr    = 1'b0;
        buf_shift  = 1'b0;

        if (ev_valid) begin
            case (kind)
                EV_START, EV_STOP: begin
                    // a stop or repeated start closes the current chunk
                    if (s_q.phase == PH_DATA) begin
                        if (s_q.cnt == CNT_W'(CHUNK_BYTES)) begin
                            if (fill_inc == s_q.words) begin
                                s_d.commit = 1'b1;
                                s_d.open   = 1'b0;
                                s_d.fill   = '0;
                            end else begin
                                s_d.open   = 1'b1;
                                s_d.fill   = fill_inc;
                            end
                        end else if (s_q.cnt == '0 && !s_q.append) begin
                            s_d.open = 1'b0;
                        end else begin
                            s_d.flush = 1'b1;
                            s_d.open  = 1'b0;
                            s_d.fill  = '0;
                            buf_clr   = 1'b1;
                        end
                    end
                    s_d.phase = (kind == EV_START) ? PH_ADDR : PH_IDLE;
                end
                EV_ADDR: begin
                    if (s_q.phase == PH_ADDR) begin
                        if (!addr_hit) begin
                            s_d.phase = PH_SKIP;
                        end else if (addr_read) begin
                            if (s_q.open) begin
                                s_d.flush = 1'b1;
                                s_d.open  = 1'b0;
                                s_d.fill  = '0;
                                buf_clr   = 1'b1;
                            end
                            s_d.phase = PH_SKIP;
                        end else begin
                            s_d.phase = PH_SUB;
                        end
                    end
                end
                EV_SUB: begin
                    if (s_q.phase == PH_SUB) begin
                        s_d.cnt = '0;
                        if (ev_byte == APPEND_SUB) begin
                            if (s_q.open) begin
                                s_d.append = 1'b1;
                                s_d.phase  = PH_DATA;
                            end else begin
                                s_d.flush = 1'b1;
                                s_d.phase = PH_SKIP;
                            end
                        end else begin
                            s_d.flush  = s_q.open;
                            s_d.open   = 1'b0;
                            s_d.fill   = '0;
                            s_d.append = 1'b0;
                            s_d.sub    = ev_byte;
                            s_d.words  = lut_words;
                            s_d.phase  = PH_DATA;
                            buf_clr    = 1'b1;
                        end
                    end
                end
                EV_DATA: begin
                    if (s_q.phase == PH_DATA) begin
                        if (s_q.cnt < CNT_W'(CHUNK_BYTES)) begin
                            buf_shift = 1'b1;
                            s_d.cnt   = s_q.cnt + CNT_W'(1);
                        end else begin
                            s_d.cnt   = CNT_W'(CHUNK_BYTES + 1);
                        end
                    end
                end
                default: begin
                    s_d.phase = s_q.phase;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign commit_valid = s_q.commit;
    assign commit_sub   = s_q.sub;
    assign commit_words = s_q.words;
    assign flush_pulse  = s_q.flush;

endmodule

// File: rtl/lra_append_checker.sv
`timescale 1ns/1ps
module lra_append_checker #(
    parameter logic [6:0] DEV_ADDR  = 7'h36,
    parameter int         MAX_WORDS = 5
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           ev_valid,
    input logic [2:0]                     ev_kind,
    input logic [6:0]                     ev_addr,
    input logic                           commit_valid,
    input logic [$clog2(MAX_WORDS+1)-1:0] commit_words,
    input logic                           flush_pulse
);

    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else begin
            armed_q <= 1'b1;
        end
    end

    AST_FOREIGN_ADDR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(ev_valid && ev_kind == 3'd1 && ev_addr != DEV_ADDR))
            |-> (!commit_valid && !flush_pulse)); // R1

    AST_COMMIT_WIDTH_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid |-> (commit_words != '0 && 32'(commit_words) <= MAX_WORDS)); // R2

    AST_COMMIT_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && commit_valid) |-> $past(ev_valid && (ev_kind == 3'd4 || ev_kind == 3'd0))); // R4

    AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid |=> !commit_valid); // R4

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_valid && flush_pulse)); // R10

    AST_QUIET_WITHOUT_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !$past(ev_valid)) |-> (!commit_valid && !flush_pulse)); // R10

endmodule

bind lra_append_ctrl lra_append_checker #(
    .DEV_ADDR  (DEV_ADDR),
    .MAX_WORDS (MAX_WORDS)
) u_lra_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_valid     (ev_valid),
    .ev_kind      (ev_kind),
    .ev_addr      (ev_byte[7:1]),
    .commit_valid (commit_valid),
    .commit_words (commit_words),
    .flush_pulse  (flush_pulse)
);

// File: tb/lra_append_ctrl_bench.sv
`timescale 1ns/1ps
module lra_append_ctrl_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ev_valid = 1'b0;
    logic [2:0]   ev_kind = 3'd0;
    logic [7:0]   ev_byte = 8'd0;
    logic         commit_valid;
    logic [7:0]   commit_sub;
    logic [2:0]   commit_words;
    logic [159:0] commit_data;
    logic         flush_pulse;

    always #5 clk = ~clk;

    lra_append_ctrl u_lra_append_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ev_valid     (ev_valid),
        .ev_kind      (ev_kind),
        .ev_byte      (ev_byte),
        .commit_valid (commit_valid),
        .commit_sub   (commit_sub),
        .commit_words (commit_words),
        .commit_data  (commit_data),
        .flush_pulse  (flush_pulse)
    );

    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;
    string cur_req = "R10";

    // behavioural reference state
    int             m_phase = 0;   // 0 idle 1 addr 2 sub 3 data 4 skip
    bit             m_open  = 1'b0;
    bit             m_app   = 1'b0;
    int             m_total = 4;
    int             m_sub   = 0;
    int             m_cnt   = 0;
    byte unsigned   m_held[$];
    byte unsigned   m_chunk[$];
    bit             e_commit = 1'b0;
    bit             e_flush  = 1'b0;
    logic [159:0]   e_data   = '0;
    int             e_sub    = 0;
    int             e_words  = 0;

    function automatic int width_of(int s);
        if (s >= 8'h40 && s <= 8'h4F) return 8;
        if (s >= 8'h50 && s <= 8'h5F) return 12;
        if (s >= 8'h60 && s <= 8'h6F) return 20;
        return 4;
    endfunction

    task automatic m_discard();
        e_flush = 1'b1;
        m_open  = 1'b0;
        m_held.delete();
    endtask

    task automatic m_close_chunk();
        if (m_cnt == 4) begin
            foreach (m_chunk[i]) m_held.push_back(m_chunk[i]);
            if (m_held.size() == m_total) begin
                e_commit = 1'b1;
                e_data   = '0;
                foreach (m_held[i]) e_data[(m_total-1-i)*8 +: 8] = m_held[i];
                e_sub    = m_sub;
                e_words  = m_total / 4;
                m_open   = 1'b0;
                m_held.delete();
            end else begin
                m_open = 1'b1;
            end
        end else if (m_cnt == 0 && !m_app) begin
            m_open = 1'b0;
        end else begin
            m_discard();
        end
    endtask

    task automatic model(input int k, input int b);
        e_commit = 1'b0;
        e_flush  = 1'b0;
        case (k)
            0, 4: begin
                if (m_phase == 3) m_close_chunk();
                m_phase = (k == 0) ? 1 : 0;
            end
            1: if (m_phase == 1) begin
                if ((b >> 1) != 8'h36) m_phase = 4;
                else if (b & 1) begin
                    if (m_open) m_discard();
                    m_phase = 4;
                end else m_phase = 2;
            end
            2: if (m_phase == 2) begin
                m_cnt = 0;
                m_chunk.delete();
                if (b == 8'hFE) begin
                    if (m_open) begin
                        m_app = 1'b1;
                        m_phase = 3;
                    end else begin
                        e_flush = 1'b1;
                        m_phase = 4;
                    end
                end else begin
                    if (m_open) m_discard();
                    m_open  = 1'b0;
                    m_held.delete();
                    m_app   = 1'b0;
                    m_sub   = b;
                    m_total = width_of(b);
                    m_phase = 3;
                end
            end
            3: if (m_phase == 3) begin
                if (m_chunk.size() < 4) m_chunk.push_back(byte'(b));
                if (m_cnt < 5) m_cnt++;
            end
            default: ;
        endcase
    endtask

    task automatic compare();
        checks++;
        if (commit_valid !== e_commit || flush_pulse !== e_flush) begin
            errors++;
            $display("FAIL %s: commit/flush actual=%b/%b expected=%b/%b",
                     cur_req, commit_valid, flush_pulse, e_commit, e_flush);
        end else if (e_commit) begin
            if (commit_data !== e_data || commit_sub !== 8'(e_sub) || commit_words !== 3'(e_words)) begin
                errors++;
                $display("FAIL %s: payload actual=%h sub=%h words=%0d expected=%h sub=%h words=%0d",
                         cur_req, commit_data, commit_sub, commit_words, e_data, e_sub, e_words);
            end
        end
    endtask

    task automatic ev(input int k, input int b);
        ev_valid = 1'b1;
        ev_kind  = 3'(k);
        ev_byte  = 8'(b);
        model(k, b);
        @(negedge clk);
        compare();
        ev_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            ev_valid = 1'b0;
            e_commit = 1'b0;
            e_flush  = 1'b0;
            @(negedge clk);
            compare();
        end
    endtask

    // one write transaction: subaddress then n bytes seed, seed+1, ...
    task automatic wr(input int addr, input int sub, input int n, input int seed);
        ev(0, 0);
        ev(1, addr);
        ev(2, sub);
        for (int i = 0; i < n; i++) ev(3, (seed + i) & 8'hFF);
        ev(4, 0);
        idle(1);
    endtask

    task automatic rd();
        ev(0, 0);
        ev(1, 8'h6D);
        ev(3, 8'h00);
        ev(4, 0);
        idle(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R10: watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R10";
        idle(3);

        cur_req = "R5";                     // single-word register, R4 format
        wr(8'h6C, 8'h10, 4, 8'hA0);

        cur_req = "R2";                     // 8-byte register in two pieces
        wr(8'h6C, 8'h42, 4, 8'h11);
        cur_req = "R3";
        wr(8'h6C, 8'hFE, 4, 8'h21);

        cur_req = "R4";                     // 20-byte register, other traffic between
        wr(8'h6C, 8'h63, 4, 8'h30);
        cur_req = "R1";
        wr(8'h6E, 8'hFE, 4, 8'h90);          // 7-bit address 0x37
        wr(8'h6E, 8'h44, 3, 8'h91);
        cur_req = "R3";
        wr(8'h6C, 8'hFE, 4, 8'h34);
        wr(8'h6C, 8'hFE, 4, 8'h38);
        wr(8'h6C, 8'hFE, 4, 8'h3C);
        cur_req = "R4";
        wr(8'h6C, 8'hFE, 4, 8'h40);

        cur_req = "R6";                     // cut-in by a new subaddress
        wr(8'h6C, 8'h55, 4, 8'h50);
        wr(8'h6C, 8'h41, 4, 8'h60);
        cur_req = "R3";
        wr(8'h6C, 8'hFE, 4, 8'h64);

        cur_req = "R7";                     // wrong chunk sizes
        wr(8'h6C, 8'h58, 4, 8'h70);
        wr(8'h6C, 8'hFE, 3, 8'h74);
        wr(8'h6C, 8'h59, 4, 8'h70);
        wr(8'h6C, 8'hFE, 5, 8'h74);
        wr(8'h6C, 8'h5A, 4, 8'h70);
        wr(8'h6C, 8'hFE, 0, 8'h00);
        wr(8'h6C, 8'h20, 2, 8'h77);
        wr(8'h6C, 8'h48, 6, 8'h78);
        cur_req = "R9";
        wr(8'h6C, 8'hFE, 4, 8'h79);          // nothing open after the errors above

        cur_req = "R8";                     // read while open
        wr(8'h6C, 8'h66, 4, 8'h80);
        rd();
        cur_req = "R9";
        wr(8'h6C, 8'hFE, 4, 8'h84);

        cur_req = "R11";                    // pointer-only write and bare read
        wr(8'h6C, 8'h30, 0, 8'h00);
        rd();
        cur_req = "R9";
        wr(8'h6C, 8'hFE, 4, 8'h88);

        cur_req = "R4";                     // repeated start ends the final chunk
        wr(8'h6C, 8'h4C, 4, 8'hC0);
        ev(0, 0);
        ev(1, 8'h6C);
        ev(2, 8'hFE);
        for (int i = 0; i < 4; i++) ev(3, 8'hC4 + i);
        ev(0, 0);
        ev(1, 8'h6E);
        ev(4, 0);

        cur_req = "R10";
        idle(4);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule